// File: doc/BRIEF.md
# Repeat-Loop and Breakpoint PC Sequencer

This block decides the program counter of the next instruction word each time one retires. It sits between the execute stage and the fetch unit. Its program counter is a word address, and the fetch unit receives the byte address derived from it. For each retiring word the block takes one of three paths: it follows a taken branch, it loops back through a zero-overhead hardware repeat loop, or it steps forward by one word.

Once that choice is made, an instruction-address breakpoint is compared against the chosen address. If debug is enabled and the two match, the block traps. It records the chosen address and the status word in backup registers, strips the live status word down to its supervisor-mode bit, and redirects execution to a fixed debug-trap vector.

The loop start address, loop end address and breakpoint address are held outside the block and arrive as inputs. The loop count and the status word also arrive as inputs, and the block returns their updated values so the owner can write them back. Every update takes effect on a single clock edge, and only when the retire strobe is high.

Top module: `rpt_pc_sequencer`

## Requirements
- R1: After reset the program counter is RESET_PC (default 0xFFC0), the fetch address is 0x3FF00, and the count, status, backup PC, backup status, loop-exit pulse and trap pulse outputs are all zero.
- R2: On a clock edge where `retire` is low, no output changes, whatever the other inputs are doing.
- R3: When `pcChanged` is high at retire, the next PC is `branchTgt`. The loop check is skipped even if repeat is enabled and the PC equals `repEnd`, so the count and the status pass through unchanged.
- R4: When `pcChanged` is low, status bit RP_BIT (default 7) is set, the PC equals `repEnd` and `repCount` is not 1, the next PC is `repStart` and the count output becomes `repCount - 1`. A count of 0 is not 1, so it wraps to all ones.
- R5: When `pcChanged` is low, status bit RP_BIT is set, the PC equals `repEnd` and `repCount` is 1, the next PC is PC+1. The count output becomes 0, bit RP_BIT of the returned status is cleared, and `rptClr` is high for the one cycle after that edge.
- R6: In every other retire without a branch, the next PC is PC+1, and the value wraps modulo 2^PC_W. This includes the case where the PC equals `repEnd` with RP_BIT clear.
- R7: When status bit DB_BIT (default 12) is set and the next PC chosen by R3 to R6 equals `bkptAddr`, several things happen on the same edge. `savedPc` takes that chosen PC. `savedStatus` takes the status as it stands after any R5 clear. The returned status keeps only bit SM_BIT (default 15). The PC loads TRAP_VEC, and `trapHit` is high for one cycle.
- R8: The breakpoint takes precedence over a loop-back, a loop exit and a taken branch. The count update of R4 and R5 still takes effect on that edge.
- R9: With DB_BIT clear, a match against `bkptAddr` has no effect: there is no trap, and `savedPc` and `savedStatus` keep their values.
- R10: `fetchAddr` always equals the PC shifted left by two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| retire | input | 1 | Instruction word retires; commit all updates |
| pcChanged | input | 1 | The retiring word took a branch |
| branchTgt | input | PC_W | Branch target word address |
| repStart | input | PC_W | Repeat loop first word address |
| repEnd | input | PC_W | Repeat loop last word address |
| repCount | input | CNT_W | Current repeat count |
| bkptAddr | input | PC_W | Breakpoint word address |
| statusIn | input | ST_W | Current status word |
| pcQ | output | PC_W | Program counter (word address) |
| fetchAddr | output | PC_W+2 | Byte fetch address |
| countQ | output | CNT_W | Updated repeat count |
| statusQ | output | ST_W | Updated status word |
| rptClr | output | 1 | One-cycle pulse: loop finished, repeat enable cleared |
| trapHit | output | 1 | One-cycle pulse: breakpoint trap taken |
| savedPc | output | PC_W | Backup PC captured on trap |
| savedStatus | output | ST_W | Backup status captured on trap |

## Verification
The bench builds the block with a 16-bit PC, count and status word, a reset PC of 0xFFC0 and a trap vector of 0xFF00. The supervisor, debug and repeat bits are placed at 15, 12 and 7. Because the three bits sit apart, the bench can tell which one a mask kept or cleared. The 16-bit PC lets a single branch reach 0xFFFF and so exercise the wrap. The 16-bit count lets the zero-count case produce a visible decrement to 0xFFFF.

// File: rtl/rpt_pc_pkg.sv
package rpt_pc_pkg;

  // Next-PC source chosen by the control, before the breakpoint compare.
  typedef struct packed {
    logic takeBranch;
    logic loopBack;
    logic loopExit;
  } seqSel_t;

  // Commit strobes, produced once the candidate PC is known.
  typedef struct packed {
    logic commit;
    logic trap;
  } seqCommit_t;

endpackage

// File: rtl/rpt_pc_ctrl.sv
module rpt_pc_ctrl
  import rpt_pc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int CNT_W  = 16,
  parameter int ST_W   = 16,
  parameter int RP_BIT = 7,
  parameter int DB_BIT = 12
) (
  input  logic             retire,
  input  logic             pcChanged,
  input  logic [PC_W-1:0]  pcQ,
  input  logic [PC_W-1:0]  repEnd,
  input  logic [CNT_W-1:0] repCount,
  input  logic [ST_W-1:0]  statusIn,
  input  logic             candMatch,
  output seqSel_t          sel,
  output seqCommit_t       cmt
);

  logic atLoopEnd;
  logic lastPass;

  assign atLoopEnd = !pcChanged && statusIn[RP_BIT] && (pcQ == repEnd);
  assign lastPass  = (repCount == CNT_W'(1));

  always_comb begin
    sel.takeBranch = pcChanged;
    sel.loopBack   = atLoopEnd && !lastPass;
    sel.loopExit   = atLoopEnd && lastPass;
  end

  always_comb begin
    cmt.commit = retire;
    cmt.trap   = retire && statusIn[DB_BIT] && candMatch;
  end

endmodule

// File: rtl/rpt_pc_dpath.sv
module rpt_pc_dpath
  import rpt_pc_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter int              CNT_W    = 16,
  parameter int              ST_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = 16'hFFC0,
  parameter logic [PC_W-1:0] TRAP_VEC = 16'hFF00,
  parameter int              SM_BIT   = 15,
  parameter int              RP_BIT   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqSel_t          sel,
  input  seqCommit_t       cmt,
  input  logic [PC_W-1:0]  branchTgt,
  input  logic [PC_W-1:0]  repStart,
  input  logic [CNT_W-1:0] repCount,
  input  logic [PC_W-1:0]  bkptAddr,
  input  logic [ST_W-1:0]  statusIn,
  output logic             candMatch,
  output logic [PC_W-1:0]  pcQ,
  output logic [CNT_W-1:0] countQ,
  output logic [ST_W-1:0]  statusQ,
  output logic             rptClr,
  output logic             trapHit,
  output logic [PC_W-1:0]  savedPc,
  output logic [ST_W-1:0]  savedStatus
);

  logic [PC_W-1:0]  seqPc;
  logic [PC_W-1:0]  candPc;
  logic [PC_W-1:0]  pcNext;
  logic [CNT_W-1:0] countNext;
  logic [ST_W-1:0]  statusMid;
  logic [ST_W-1:0]  statusNext;

  assign seqPc = pcQ + PC_W'(1);

  always_comb begin
    if (sel.takeBranch)    candPc = branchTgt;
    else if (sel.loopBack) candPc = repStart;
    else                   candPc = seqPc;
  end

  assign candMatch = (candPc == bkptAddr);
  assign pcNext    = cmt.trap ? TRAP_VEC : candPc;

  always_comb begin
    if (sel.loopBack)      countNext = repCount - CNT_W'(1);
    else if (sel.loopExit) countNext = '0;
    else                   countNext = repCount;
  end

  // Per-bit status rebuild: repeat bit cleared on loop exit,
  // everything except supervisor bit cleared on trap.
  for (genvar b = 0; b < ST_W; b++) begin : g_stBit
    if (b == RP_BIT) begin : g_rp
      assign statusMid[b] = statusIn[b] & ~sel.loopExit;
    end else begin : g_pass
      assign statusMid[b] = statusIn[b];
    end
    if (b == SM_BIT) begin : g_keep
      assign statusNext[b] = statusMid[b];
    end else begin : g_mask
      assign statusNext[b] = statusMid[b] & ~cmt.trap;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ         <= RESET_PC;
      countQ      <= '0;
      statusQ     <= '0;
      rptClr      <= 1'b0;
      trapHit     <= 1'b0;
      savedPc     <= '0;
      savedStatus <= '0;
    end else begin
      rptClr  <= cmt.commit && sel.loopExit;
      trapHit <= cmt.trap;
      if (cmt.commit) begin
        pcQ     <= pcNext;
        countQ  <= countNext;
        statusQ <= statusNext;
      end
      if (cmt.trap) begin
        savedPc     <= candPc;
        savedStatus <= statusMid;
      end
    end
  end

endmodule

// File: rtl/rpt_pc_sequencer.sv
module rpt_pc_sequencer
  import rpt_pc_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter int              CNT_W    = 16,
  parameter int              ST_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = 16'hFFC0,
  parameter logic [PC_W-1:0] TRAP_VEC = 16'hFF00,
  parameter int              SM_BIT   = 15,
  parameter int              DB_BIT   = 12,
  parameter int              RP_BIT   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               retire,
  input  logic               pcChanged,
  input  logic [PC_W-1:0]    branchTgt,
  input  logic [PC_W-1:0]    repStart,
  input  logic [PC_W-1:0]    repEnd,
  input  logic [CNT_W-1:0]   repCount,
  input  logic [PC_W-1:0]    bkptAddr,
  input  logic [ST_W-1:0]    statusIn,
  output logic [PC_W-1:0]    pcQ,
  output logic [PC_W+1:0]    fetchAddr,
  output logic [CNT_W-1:0]   countQ,
  output logic [ST_W-1:0]    statusQ,
  output logic               rptClr,
  output logic               trapHit,
  output logic [PC_W-1:0]    savedPc,
  output logic [ST_W-1:0]    savedStatus
);

  localparam int BYTE_SHIFT = 2;

  seqSel_t    sel;
  seqCommit_t cmt;
  logic       candMatch;

  rpt_pc_ctrl #(
    .PC_W(PC_W), .CNT_W(CNT_W), .ST_W(ST_W),
    .RP_BIT(RP_BIT), .DB_BIT(DB_BIT)
  ) u_ctrl (
    .retire(retire), .pcChanged(pcChanged), .pcQ(pcQ), .repEnd(repEnd),
    .repCount(repCount), .statusIn(statusIn), .candMatch(candMatch),
    .sel(sel), .cmt(cmt)
  );

  rpt_pc_dpath #(
    .PC_W(PC_W), .CNT_W(CNT_W), .ST_W(ST_W), .RESET_PC(RESET_PC),
    .TRAP_VEC(TRAP_VEC), .SM_BIT(SM_BIT), .RP_BIT(RP_BIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .sel(sel), .cmt(cmt), .branchTgt(branchTgt),
    .repStart(repStart), .repCount(repCount), .bkptAddr(bkptAddr),
    .statusIn(statusIn), .candMatch(candMatch), .pcQ(pcQ), .countQ(countQ),
    .statusQ(statusQ), .rptClr(rptClr), .trapHit(trapHit),
    .savedPc(savedPc), .savedStatus(savedStatus)
  );

  assign fetchAddr = {pcQ, {BYTE_SHIFT{1'b0}}};

endmodule

// File: rtl/rpt_pc_sequencer_chk.sv
module rpt_pc_sequencer_chk #(
  parameter int              PC_W     = 16,
  parameter int              CNT_W    = 16,
  parameter int              ST_W     = 16,
  parameter logic [PC_W-1:0] TRAP_VEC = 16'hFF00,
  parameter int              DB_BIT   = 12,
  parameter int              RP_BIT   = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             retire,
  input logic             pcChanged,
  input logic [PC_W-1:0]  branchTgt,
  input logic [PC_W-1:0]  repEnd,
  input logic [CNT_W-1:0] repCount,
  input logic [ST_W-1:0]  statusIn,
  input logic [PC_W-1:0]  pcQ,
  input logic [CNT_W-1:0] countQ,
  input logic             rptClr,
  input logic             trapHit,
  input logic [PC_W-1:0]  savedPc
);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !retire |=> ($stable(pcQ) && $stable(countQ) && $stable(savedPc)));

  // R3
  branch_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && pcChanged) |=> (trapHit || pcQ == $past(branchTgt)));

  // R4
  loop_decrement_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !pcChanged && statusIn[RP_BIT] && pcQ == repEnd && repCount != CNT_W'(1))
      |=> (countQ == CNT_W'($past(repCount) - CNT_W'(1))));

  // R5
  loop_exit_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    rptClr |-> (countQ == '0));

  // R7
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapHit |-> (pcQ == TRAP_VEC));

  // R9
  no_trap_without_debug_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !statusIn[DB_BIT]) |=> !trapHit);

endmodule

bind rpt_pc_sequencer rpt_pc_sequencer_chk #(
  .PC_W(PC_W), .CNT_W(CNT_W), .ST_W(ST_W), .TRAP_VEC(TRAP_VEC),
  .DB_BIT(DB_BIT), .RP_BIT(RP_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .retire(retire), .pcChanged(pcChanged),
  .branchTgt(branchTgt), .repEnd(repEnd), .repCount(repCount),
  .statusIn(statusIn), .pcQ(pcQ), .countQ(countQ), .rptClr(rptClr),
  .trapHit(trapHit), .savedPc(savedPc)
);

// File: tb/tb_rpt_pc_sequencer.sv
module tb_rpt_pc_sequencer;

  localparam int              PC_W  = 16;
  localparam int              CNT_W = 16;
  localparam int              ST_W  = 16;
  localparam logic [15:0]     RST_PC = 16'hFFC0;
  localparam logic [15:0]     TVEC   = 16'hFF00;
  localparam logic [15:0]     SM = 16'h8000;
  localparam logic [15:0]     DB = 16'h1000;
  localparam logic [15:0]     RP = 16'h0080;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retire = 1'b0;
  logic pcChanged = 1'b0;
  logic [PC_W-1:0]  branchTgt = '0;
  logic [PC_W-1:0]  repStart = '0;
  logic [PC_W-1:0]  repEnd = '0;
  logic [CNT_W-1:0] repCount = '0;
  logic [PC_W-1:0]  bkptAddr = '0;
  logic [ST_W-1:0]  statusIn = '0;
  logic [PC_W-1:0]  pcQ;
  logic [PC_W+1:0]  fetchAddr;
  logic [CNT_W-1:0] countQ;
  logic [ST_W-1:0]  statusQ;
  logic             rptClr;
  logic             trapHit;
  logic [PC_W-1:0]  savedPc;
  logic [ST_W-1:0]  savedStatus;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  rpt_pc_sequencer #(
    .PC_W(PC_W), .CNT_W(CNT_W), .ST_W(ST_W), .RESET_PC(RST_PC),
    .TRAP_VEC(TVEC), .SM_BIT(15), .DB_BIT(12), .RP_BIT(7)
  ) dut (
    .clk(clk), .rstN(rstN), .retire(retire), .pcChanged(pcChanged),
    .branchTgt(branchTgt), .repStart(repStart), .repEnd(repEnd),
    .repCount(repCount), .bkptAddr(bkptAddr), .statusIn(statusIn),
    .pcQ(pcQ), .fetchAddr(fetchAddr), .countQ(countQ), .statusQ(statusQ),
    .rptClr(rptClr), .trapHit(trapHit), .savedPc(savedPc),
    .savedStatus(savedStatus)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One retiring word with the inputs as currently set; sample at next negedge.
  task automatic retireOne();
    retire = 1'b1;
    @(posedge clk);
    @(negedge clk);
    retire = 1'b0;
  endtask

  // Move the PC with a plain branch, debug and repeat off.
  task automatic jumpTo(input logic [15:0] tgt);
    statusIn = '0; pcChanged = 1'b1; branchTgt = tgt;
    retireOne();
    pcChanged = 1'b0;
  endtask

  task automatic tReset();
    check("R1", "pc", pcQ, RST_PC);
    check("R10", "fetchAddr at reset", fetchAddr, 32'h3FF00);
    check("R1", "count", countQ, 0);
    check("R1", "status", statusQ, 0);
    check("R1", "pulses", {rptClr, trapHit}, 0);
    check("R1", "saved", {savedPc, savedStatus}, 0);
  endtask

  task automatic tSequential();
    statusIn = 16'h0055; repCount = 16'h0009;
    retireOne();
    check("R6", "pc step", pcQ, 16'hFFC1);
    check("R10", "fetchAddr", fetchAddr, 32'h3FF04);
    check("R6", "status pass", statusQ, 16'h0055);
    check("R6", "count pass", countQ, 16'h0009);
  endtask

  task automatic tHold();
    logic [15:0] pcBefore;
    pcBefore = pcQ;
    pcChanged = 1'b1; branchTgt = 16'h1234; statusIn = DB | RP; bkptAddr = 16'h1234;
    repeat (3) @(negedge clk);
    check("R2", "pc held", pcQ, pcBefore);
    check("R2", "trap idle", trapHit, 0);
    check("R2", "saved held", savedPc, 0);
    pcChanged = 1'b0; statusIn = '0;
  endtask

  task automatic tBranchAtEnd();
    repStart = 16'h0018; repEnd = 16'h0020;
    jumpTo(16'h0020);
    statusIn = RP; repCount = 16'h0003; pcChanged = 1'b1; branchTgt = 16'h0050;
    retireOne();
    pcChanged = 1'b0;
    check("R3", "branch wins at loop end", pcQ, 16'h0050);
    check("R3", "count untouched", countQ, 16'h0003);
    check("R3", "status untouched", statusQ, RP);
    check("R3", "no exit pulse", rptClr, 0);
  endtask

  task automatic tLoopBack();
    jumpTo(16'h0020);
    statusIn = RP; repCount = 16'h0003;
    retireOne();
    check("R4", "pc to start", pcQ, 16'h0018);
    check("R4", "count dec", countQ, 16'h0002);
    check("R4", "no exit pulse", rptClr, 0);
  endtask

  task automatic tLoopZero();
    jumpTo(16'h0020);
    statusIn = RP; repCount = 16'h0000;
    retireOne();
    check("R4", "zero count loops", pcQ, 16'h0018);
    check("R4", "zero count wraps", countQ, 16'hFFFF);
  endtask

  task automatic tLoopExit();
    jumpTo(16'h0020);
    statusIn = RP | 16'h0003; repCount = 16'h0001;
    retireOne();
    check("R5", "pc advances", pcQ, 16'h0021);
    check("R5", "count cleared", countQ, 0);
    check("R5", "repeat bit cleared", statusQ, 16'h0003);
    check("R5", "exit pulse", rptClr, 1);
    @(negedge clk);
    check("R5", "exit pulse one cycle", rptClr, 0);
  endtask

  task automatic tRepeatOff();
    jumpTo(16'h0020);
    statusIn = '0; repCount = 16'h0004;
    retireOne();
    check("R6", "repeat off at end", pcQ, 16'h0021);
    check("R6", "count pass", countQ, 16'h0004);
  endtask

  task automatic tWrap();
    jumpTo(16'hFFFF);
    retireOne();
    check("R6", "wrap", pcQ, 16'h0000);
    check("R10", "fetchAddr wrap", fetchAddr, 0);
  endtask

  task automatic tBkptSeq();
    jumpTo(16'h0100);
    statusIn = SM | DB | 16'h0005; bkptAddr = 16'h0101;
    retireOne();
    check("R7", "trap vector", pcQ, TVEC);
    check("R7", "saved pc", savedPc, 16'h0101);
    check("R7", "saved status", savedStatus, SM | DB | 16'h0005);
    check("R7", "status masked", statusQ, SM);
    check("R7", "trap pulse", trapHit, 1);
    @(negedge clk);
    check("R7", "trap pulse one cycle", trapHit, 0);
  endtask

  task automatic tBkptLoopBack();
    jumpTo(16'h0020);
    statusIn = SM | DB | RP; repCount = 16'h0003; bkptAddr = 16'h0018;
    retireOne();
    check("R8", "trap over loop-back", pcQ, TVEC);
    check("R8", "saved loop start", savedPc, 16'h0018);
    check("R8", "count still dec", countQ, 16'h0002);
    check("R8", "saved status", savedStatus, SM | DB | RP);
  endtask

  task automatic tBkptExit();
    jumpTo(16'h0020);
    statusIn = DB | RP; repCount = 16'h0001; bkptAddr = 16'h0021;
    retireOne();
    check("R8", "trap over exit", pcQ, TVEC);
    check("R8", "saved status after clear", savedStatus, DB);
    check("R8", "count cleared", countQ, 0);
    check("R8", "both pulses", {rptClr, trapHit}, 2'b11);
    check("R8", "status masked (SM off)", statusQ, 0);
  endtask

  task automatic tBkptBranch();
    jumpTo(16'h0040);
    statusIn = DB; pcChanged = 1'b1; branchTgt = 16'h0777; bkptAddr = 16'h0777;
    retireOne();
    pcChanged = 1'b0;
    check("R8", "trap over branch", pcQ, TVEC);
    check("R8", "saved branch target", savedPc, 16'h0777);
  endtask

  task automatic tNoDebug();
    jumpTo(16'h0300);
    statusIn = SM | 16'h0005; bkptAddr = 16'h0301;
    retireOne();
    check("R9", "no trap pc", pcQ, 16'h0301);
    check("R9", "no pulse", trapHit, 0);
    check("R9", "saved pc kept", savedPc, 16'h0777);
    check("R9", "saved status kept", savedStatus, DB);
    check("R9", "status unmasked", statusQ, SM | 16'h0005);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSequential();
    tHold();
    tBranchAtEnd();
    tLoopBack();
    tLoopZero();
    tLoopExit();
    tRepeatOff();
    tWrap();
    tBkptSeq();
    tBkptLoopBack();
    tBkptExit();
    tBkptBranch();
    tNoDebug();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule